// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an asynchronous DRAM array out of power-up and then keeps its contents alive. Once the power-good input is high, it stays idle for a fixed pause. It then runs a counted burst of refresh cycles as the initialization sequence. Only after that does it raise `ready`, which tells the access controller that it may begin normal read and write cycles.

From then on, an interval timer marks one refresh as owed every `REF_INTERVAL` clocks. The block asks the access controller for the pins with `ref_req`. It starts a refresh cycle only in a clock where `ref_gnt` is high, so an access already in progress finishes first. Each refresh is either CAS-before-RAS, in which the DRAM supplies its own row, or RAS-only, in which the block drives an internal row counter onto the address pins. The `use_ras_only` input selects between them when each cycle starts.

Refreshes that cannot run are counted in a backlog. When the backlog grows past `OVERDUE_MAX`, a sticky error flag is raised. All timing is counted in clock cycles; the defaults assume a 100 MHz clock.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are as follows: `ready`=0, `ras_n`=1, `cas_n`=1, `ref_req`=0, `pins_own`=0 and `overdue_err`=0. Reset is the only thing that clears `overdue_err`.
- R2: With `pwr_good` low, no RAS or CAS strobe is driven. After `pwr_good` rises, RAS stays high for at least `PAUSE_CYC` clocks. If `pwr_good` drops at any time, `ready` clears and the whole sequence restarts.
- R3: After the pause, exactly `INIT_CYCLES` refresh cycles run without needing `ref_gnt`. `ready` rises in the clock after the precharge of the last of these cycles.
- R4: In a CAS-before-RAS cycle (`use_ras_only`=0 at cycle start), `cas_n` falls `T_SETUP` clocks before `ras_n` falls. `we_n` is 1, `cas_n` stays low for the whole RAS-low time, and both strobes rise together.
- R5: In a RAS-only cycle (`use_ras_only`=1), `cas_n` stays 1 and `row_addr` carries the row counter. The counter advances by one after each RAS-only cycle and wraps from 2^`ROW_BITS`-1 to 0. CAS-before-RAS cycles leave it unchanged.
- R6: `ras_n` is low for exactly `T_RAS` clocks per refresh. Between two refreshes it is high for at least `T_PRE` clocks.
- R7: After `ready`, one refresh becomes owed every `REF_INTERVAL` clocks. `ref_req` is 1 while any refresh is owed or a refresh cycle is in progress.
- R8: After `ready`, a refresh cycle starts only in a clock where `ref_gnt` is 1. While `ref_gnt` is 0, no new RAS strobe occurs.
- R9: `overdue_err` rises when the owed count exceeds `OVERDUE_MAX` and then stays high.
- R10: The refresh mode is taken from `use_ras_only` only when a cycle starts. A change during the cycle does not alter its strobes.
- R11: Owed refreshes accumulate while the grant is withheld. Once the grant returns they run back to back, one every `T_SETUP+T_RAS+T_PRE+1` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_good | input | 1 | Supply stable indication |
| use_ras_only | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS |
| ref_gnt | input | 1 | Access controller releases the DRAM pins |
| ready | output | 1 | Initialization finished; accesses allowed |
| ref_req | output | 1 | Refresh owed or in progress |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high during refresh |
| row_addr | output | ROW_BITS | Row counter for RAS-only refresh |
| pins_own | output | 1 | This block is driving the strobes |
| overdue_err | output | 1 | Sticky backlog overflow flag |

## Verification
The hardest states to reach from the ports are the overflowing refresh backlog and the wrap of the row counter. The bench waits until nothing is owed and then withholds the grant for a measured number of intervals. A short window that must stay below the limit is followed by a long window that must exceed it. After the long window the bench restores the grant and counts the back-to-back drain. For the wrap, it forces RAS-only mode with a constant grant until more than 2^`ROW_BITS` cycles have run, on top of an earlier random mix of grants and modes.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_PAUSE,
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_PRECH
    } rfs_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/rfs_tick_gen.sv
module rfs_tick_gen #(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = $clog2(INTERVAL + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (cnt_q == W'(INTERVAL - 1))
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == W'(INTERVAL - 1));

    // R7: owed refreshes are spaced, never two in adjacent clocks
    a_r7_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        (INTERVAL > 1) && tick |=> !tick);
endmodule

// File: rtl/rfs_backlog.sv
module rfs_backlog #(
    parameter int LIMIT  = 4,
    parameter int PEND_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic take,
    output logic owed,
    output logic overdue_err
);
    typedef struct packed {
        logic [PEND_W-1:0] pend;
        logic              err;
    } blog_t;

    blog_t q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d.pend = '0;
        end else if (tick && !take) begin
            if (q.pend != '1) d.pend = q.pend + 1'b1;
        end else if (take && !tick) begin
            d.pend = q.pend - 1'b1;
        end
        if (d.pend > PEND_W'(LIMIT)) d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign owed        = (q.pend != '0);
    assign overdue_err = q.err;

    // R9: the overflow flag never clears without reset
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overdue_err |=> overdue_err);
    // R11: a refresh is only consumed when one is owed
    a_r11_take_when_owed: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> owed);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import rfs_pkg::*;
#(
    parameter int ROW_BITS     = 11,
    parameter int PAUSE_CYC    = 20000,
    parameter int INIT_CYCLES  = 8,
    parameter int REF_INTERVAL = 1560,
    parameter int T_SETUP      = 1,
    parameter int T_RAS        = 5,
    parameter int T_PRE        = 3,
    parameter int OVERDUE_MAX  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_good,
    input  logic                use_ras_only,
    input  logic                ref_gnt,
    output logic                ready,
    output logic                ref_req,
    output logic                ras_n,
    output logic                cas_n,
    output logic                we_n,
    output logic [ROW_BITS-1:0] row_addr,
    output logic                pins_own,
    output logic                overdue_err
);
    localparam int MAXT   = imax(imax(PAUSE_CYC, T_SETUP), imax(T_RAS, T_PRE));
    localparam int CNT_W  = $clog2(MAXT + 1);
    localparam int INIT_W = $clog2(INIT_CYCLES + 1);
    localparam int PEND_W = $clog2(OVERDUE_MAX + 2) + 1;

    typedef struct packed {
        rfs_state_e          st;
        logic [CNT_W-1:0]    cnt;
        logic [INIT_W-1:0]   init_n;
        logic                done;
        logic                cbr;
        logic [ROW_BITS-1:0] row;
    } seq_t;

    seq_t q, d;
    logic take, tick, owed;

    rfs_tick_gen #(.INTERVAL(REF_INTERVAL)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.done),
        .tick (tick)
    );

    rfs_backlog #(.LIMIT(OVERDUE_MAX), .PEND_W(PEND_W)) u_backlog (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (!q.done),
        .tick       (tick),
        .take       (take),
        .owed       (owed),
        .overdue_err(overdue_err)
    );

    always_comb begin
        d    = q;
        take = 1'b0;
        if (!pwr_good) begin
            d.st     = ST_OFF;
            d.cnt    = '0;
            d.init_n = '0;
            d.done   = 1'b0;
        end else begin
            case (q.st)
                ST_OFF: begin
                    d.st  = ST_PAUSE;
                    d.cnt = '0;
                end
                ST_PAUSE: begin
                    if (q.cnt == CNT_W'(PAUSE_CYC - 1)) begin
                        d.st  = ST_SETUP;
                        d.cnt = '0;
                        d.cbr = !use_ras_only;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (q.done && owed && ref_gnt) begin
                        d.st  = ST_SETUP;
                        d.cnt = '0;
                        d.cbr = !use_ras_only;
                        take  = 1'b1;
                    end
                end
                ST_SETUP: begin
                    if (q.cnt == CNT_W'(T_SETUP - 1)) begin
                        d.st  = ST_ACTIVE;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_ACTIVE: begin
                    if (q.cnt == CNT_W'(T_RAS - 1)) begin
                        d.st  = ST_PRECH;
                        d.cnt = '0;
                        if (!q.cbr) d.row = q.row + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_PRECH: begin
                    if (q.cnt == CNT_W'(T_PRE - 1)) begin
                        d.cnt = '0;
                        if (q.done) begin
                            d.st = ST_IDLE;
                        end else if (q.init_n == INIT_W'(INIT_CYCLES - 1)) begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                        end else begin
                            d.st     = ST_SETUP;
                            d.init_n = q.init_n + 1'b1;
                            d.cbr    = !use_ras_only;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.st = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_OFF;
            q.cbr <= 1'b1;
        end else begin
            q <= d;
        end
    end

    logic in_cycle;
    assign in_cycle = (q.st == ST_SETUP) || (q.st == ST_ACTIVE) || (q.st == ST_PRECH);

    assign ready    = q.done;
    assign ref_req  = q.done && (owed || in_cycle);
    assign pins_own = in_cycle;
    assign ras_n    = (q.st != ST_ACTIVE);
    assign cas_n    = !(q.cbr && ((q.st == ST_SETUP) || (q.st == ST_ACTIVE)));
    assign we_n     = 1'b1;
    assign row_addr = q.row;

    // R4: CAS is already low in the clock before RAS falls in CBR mode
    a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> $past(!cas_n));
    // R5: RAS-only cycles keep CAS high
    a_r5_rasonly_cas_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !q.cbr) |-> cas_n);
    // R5: the row counter steps by one after each RAS-only strobe
    a_r5_row_advance: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras_n) && q.st == ST_PRECH && !q.cbr) |->
            row_addr == ROW_BITS'($past(row_addr) + 1'b1));
    // R8: a post-init cycle starts only under grant
    a_r8_start_needs_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SETUP && $past(q.st) == ST_IDLE) |-> $past(ref_gnt));
    // R10: strobe mode does not change while RAS is low
    a_r10_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ACTIVE && $past(q.st) == ST_ACTIVE) |-> $stable(cas_n));
    // R3: ready comes out of the last precharge
    a_r3_ready_after_prech: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(q.st) == ST_PRECH);
endmodule

// File: tb/dram_refresh_seq_bench.sv
module dram_refresh_seq_bench;
    localparam int ROWB  = 11;
    localparam int PAUSE = 50;
    localparam int INITN = 8;
    localparam int RINT  = 12;
    localparam int TSET  = 1;
    localparam int TRAS  = 5;
    localparam int TPRE  = 3;
    localparam int OVMAX = 3;

    logic clk = 1'b0, rst_n, pwr_good, use_ras_only, ref_gnt;
    logic ready, ref_req, ras_n, cas_n, we_n, pins_own, overdue_err;
    logic [ROWB-1:0] row_addr;

    dram_refresh_seq #(
        .ROW_BITS(ROWB), .PAUSE_CYC(PAUSE), .INIT_CYCLES(INITN),
        .REF_INTERVAL(RINT), .T_SETUP(TSET), .T_RAS(TRAS), .T_PRE(TPRE),
        .OVERDUE_MAX(OVMAX)
    ) u_dram_refresh_seq (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .use_ras_only(use_ras_only),
        .ref_gnt(ref_gnt), .ready(ready), .ref_req(ref_req), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .row_addr(row_addr), .pins_own(pins_own),
        .overdue_err(overdue_err)
    );

    always #5 clk = ~clk;

    int nchk = 0, nfail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int next_row(input int r);
        return (r + 1) % (1 << ROWB);
    endfunction

    // pin monitor
    int  nfall = 0, init_falls = 0, lo_len = 0, hi_len = 0, pg_cnt = 0;
    int  exp_row = 0, rasonly_cnt = 0, wraps = 0;
    bit  p_ras = 1, p_cas = 1, ready_seen = 0, had_rise = 0, gnt_seen = 0;
    bit  pg_fall_seen = 0, cyc_cas = 1, cyc_cbr = 1;

    always @(negedge clk) begin
        if (!rst_n) begin
            nfall = 0; init_falls = 0; lo_len = 0; hi_len = 0; pg_cnt = 0;
            exp_row = 0; rasonly_cnt = 0; wraps = 0;
            p_ras = 1; p_cas = 1; ready_seen = 0; had_rise = 0; gnt_seen = 0;
            pg_fall_seen = 0;
        end else begin
            if (!pwr_good) begin
                pg_cnt = 0; pg_fall_seen = 0;
                chk(ras_n && cas_n, "R2 no strobes without power", {ras_n, cas_n}, 3);
            end else if (!pg_fall_seen && ras_n) begin
                pg_cnt++;
            end
            if (!ready) begin
                if (ready_seen) begin ready_seen = 0; init_falls = 0; end
            end else if (!ready_seen) begin
                ready_seen = 1;
                chk(init_falls == INITN, "R3 init refresh count", init_falls, INITN);
                chk(ras_n && hi_len >= TPRE, "R3 ready after precharge", hi_len, TPRE);
            end
            if (ref_gnt) gnt_seen = 1;
            if (p_ras && !ras_n) begin
                nfall++;
                if (!ready_seen) init_falls++;
                else chk(gnt_seen, "R8 refresh started under grant", gnt_seen, 1);
                gnt_seen = 0;
                if (!pg_fall_seen) begin
                    pg_fall_seen = 1;
                    chk(pg_cnt >= PAUSE + TSET && pg_cnt <= PAUSE + TSET + 1,
                        "R2 power-up pause", pg_cnt, PAUSE + TSET + 1);
                end
                if (had_rise) chk(hi_len >= TPRE, "R6 precharge time", hi_len, TPRE);
                cyc_cas = cas_n;
                cyc_cbr = !cas_n;
                if (cyc_cbr) begin
                    chk(!p_cas, "R4 CAS falls before RAS", p_cas, 0);
                    chk(we_n, "R4 W high in CBR", we_n, 1);
                end else begin
                    chk(int'(row_addr) == exp_row, "R5 RAS-only row address", row_addr, exp_row);
                    if (exp_row == 0 && rasonly_cnt > 0) wraps++;
                end
                lo_len = 0;
            end
            if (!ras_n) begin
                lo_len++;
                chk(cas_n == cyc_cas, "R10 strobe mode stable in cycle", cas_n, cyc_cas);
            end
            if (!p_ras && ras_n) begin
                chk(lo_len == TRAS, "R6 RAS low width", lo_len, TRAS);
                chk(cas_n, "R4 CAS released with RAS", cas_n, 1);
                if (!cyc_cbr) begin
                    exp_row = next_row(exp_row);
                    rasonly_cnt++;
                end
                had_rise = 1;
                hi_len = 0;
            end
            if (ras_n) hi_len++;
            p_ras = ras_n;
            p_cas = cas_n;
        end
    end

    initial begin
        int c0;
        void'($urandom(32'd4242));
        rst_n = 0; pwr_good = 0; ref_gnt = 0; use_ras_only = 0;
        repeat (3) step();
        @(negedge clk);
        chk(!ready, "R1 ready low in reset", ready, 0);
        chk(ras_n && cas_n, "R1 strobes high in reset", {ras_n, cas_n}, 3);
        chk(!ref_req && !pins_own, "R1 no request in reset", {ref_req, pins_own}, 0);
        chk(!overdue_err, "R1 error clear in reset", overdue_err, 0);
        step(); rst_n = 1;
        repeat (5) step();
        pwr_good = 1;
        for (int i = 0; i < 2000 && !ready; i++) step();
        chk(ready, "R3 ready after init", ready, 1);

        // random phase: grant and mode both vary
        for (int i = 0; i < 3000; i++) begin
            ref_gnt = 1'($urandom % 2);
            use_ras_only = 1'($urandom % 2);
            step();
        end

        // R7: refresh rate with free grant
        ref_gnt = 1; use_ras_only = 0;
        repeat (20) step();
        @(negedge clk); c0 = nfall;
        repeat (1200) step();
        @(negedge clk);
        chk((nfall - c0) >= 1200 / RINT - 1 && (nfall - c0) <= 1200 / RINT + 1,
            "R7 refresh rate", nfall - c0, 1200 / RINT);

        // R5: row counter wrap in RAS-only mode
        use_ras_only = 1;
        for (int i = 0; i < 60000 && wraps == 0; i++) step();
        chk(wraps >= 1, "R5 row counter wrap", wraps, 1);

        // R2: power loss restarts the sequence
        use_ras_only = 0;
        for (int i = 0; i < 100 && ref_req; i++) step();
        pwr_good = 0;
        step(); step();
        @(negedge clk);
        chk(!ready && !ref_req, "R2 ready drops on power loss", {ready, ref_req}, 0);
        pwr_good = 1;
        for (int i = 0; i < 2000 && !ready; i++) step();
        chk(ready, "R2 ready after restart", ready, 1);

        // R8/R9: short withhold stays within limit
        for (int i = 0; i < 100 && ref_req; i++) step();
        ref_gnt = 0;
        c0 = nfall;
        repeat (3 * RINT) step();
        @(negedge clk);
        chk(nfall == c0, "R8 no refresh without grant", nfall - c0, 0);
        chk(ref_req, "R7 request while owed", ref_req, 1);
        chk(!overdue_err, "R9 no error within limit", overdue_err, 0);
        ref_gnt = 1;
        repeat (60) step();
        for (int i = 0; i < 200 && ref_req; i++) step();

        // R9/R11: long withhold overflows, then drains back to back
        ref_gnt = 0;
        c0 = nfall;
        repeat (5 * RINT) step();
        @(negedge clk);
        chk(nfall == c0, "R8 no refresh during long withhold", nfall - c0, 0);
        chk(overdue_err, "R9 error on backlog overflow", overdue_err, 1);
        ref_gnt = 1;
        c0 = nfall;
        repeat (46) step();
        @(negedge clk);
        chk((nfall - c0) >= 5, "R11 backlog drains back to back", nfall - c0, 5);
        repeat (60) step();
        @(negedge clk);
        chk(overdue_err, "R9 error stays set", overdue_err, 1);

        rst_n = 0;
        step();
        @(negedge clk);
        chk(!overdue_err && !ready, "R1 reset clears error", {overdue_err, ready}, 0);

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule